// File: doc/BRIEF.md
# Circular Sample Buffer Trigger Controller

This block is the digital control of a ring-style waveform recorder. While armed, a write pointer walks around a ring of sample cells and stores one input sample on every fast clock. It wraps from the last cell back to cell zero, so the ring always holds the most recent window of the input. A trigger freezes the ring, either at once or after a programmable number of further samples. Samples taken after the trigger are then kept as well. The frozen waveform is then shifted out at a slower, divided rate. Readout starts at the cell where writing stopped, so the samples come out oldest first and in time order.

The ring is built from equal segments of `SEG_CELLS` cells. A cascade setting joins 1, 2, 4 or more segments into one longer ring. The number of cells read out can be cut down to a region of interest that starts at the stop position. No samples are written during readout. After readout the controller waits in its idle state until a new arm command arrives.

The controller has four states. IDLE is entered at reset and after readout. ACQ writes continuously. DELAY keeps writing while the latency count runs down. READ shifts out the frozen cells. The transitions are:
- arm: IDLE to ACQ.
- trigger-direct: ACQ to READ, when the latency is zero.
- trigger-delayed: ACQ to DELAY, when the latency is non-zero.
- latency-expired: DELAY to READ.
- readout-done: READ to IDLE.

Top module: `csb_trig_ctrl`

## Requirements
- R1: After reset the controller is in IDLE, with `acq_active`, `rd_valid` and `rd_last` low and `stop_cell` zero.
- R2: `arm` in IDLE starts ACQ from the next cycle (`acq_active` high). Writing starts at cell 0, stores one sample per clock and wraps from cell ring_len-1 to cell 0.
- R3: The ring length is `SEG_CELLS`·2^m, where m is `cascade_sel`, saturated at log2(`NUM_SEG`). Both `cascade_sel` and `read_len` are captured at the arm edge, and changes to them after arming have no effect on that acquisition.
- R4: A trigger in ACQ with `latency` = 0 freezes the ring at that same edge. The sample present at the trigger edge is the last one stored, and `acq_active` is low from the next cycle.
- R5: A trigger in ACQ with `latency` = L > 0 enters DELAY. Exactly L further samples are stored, then the ring freezes. `latency` is sampled at the trigger edge.
- R6: At the freeze, `stop_cell` takes the index of the cell after the last one written. This is the oldest cell. It holds that value until the next freeze.
- R7: Readout begins at `stop_cell` and walks upward, wrapping at ring_len. With a full ring, the k-th sample read equals the sample stored ring_len-1-k writes before the last write.
- R8: The number of samples read is `read_len` when it lies in 1..ring_len. Otherwise, when it is 0 or larger than ring_len, it is ring_len.
- R9: `rd_valid` is a one-cycle pulse. The k-th pulse (k from 0) is visible in the cycle after edge freeze+`RD_DIV`·(k+1).
- R10: `rd_last` is high together with the final `rd_valid` of a readout and at no other time.
- R11: No cell is written in READ or IDLE. Input samples arriving during readout do not change the data read.
- R12: `trig` is ignored in IDLE, in READ and in DELAY. A trigger in DELAY does not restart the latency count.
- R13: `arm` is ignored outside IDLE. After readout the controller stays in IDLE with `acq_active` low until a new `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start acquisition (honoured in IDLE only) |
| trig | input | 1 | Trigger event |
| cascade_sel | input | MODE_W | Segment cascade setting m, ring length SEG_CELLS·2^m |
| latency | input | LAT_W | Samples stored after the trigger sample |
| read_len | input | RL_W | Cells to read out (0 means the full ring) |
| samp_in | input | DATA_W | Incoming sample |
| acq_active | output | 1 | High in ACQ and DELAY |
| rd_valid | output | 1 | Readout sample strobe |
| rd_data | output | DATA_W | Readout sample |
| rd_last | output | 1 | Final readout sample |
| stop_cell | output | AW | Cell index where the readout begins |

## Verification
A write pointer that slips or wraps at the wrong length shows up in the first readout sample. Either `stop_cell` or `rd_data` is off from the first `rd_valid` of the run. A latency counter that is off by one shifts every read sample by one value, and `acq_active` stays high or drops a cycle early, which the port shows one cycle after the trigger. A readout sequencer with a wrong count or divider shows up as a `rd_valid` pulse in the wrong cycle, a missing or early `rd_last`, or extra samples. A controller that accepts a stray arm or trigger shows `acq_active` rising while it should stay in IDLE or READ.

// File: rtl/csb_pkg.sv
package csb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_DELAY = 2'd2,
        ST_READ  = 2'd3
    } csb_state_e;

endpackage

// File: rtl/csb_ctrl_fsm.sv
module csb_ctrl_fsm
    import csb_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             trig,
    input  logic [LAT_W-1:0] latency,
    input  logic             rd_done,
    output csb_state_e       state,
    output logic             start_acq,
    output logic             freeze,
    output logic             we,
    output logic             acq_active,
    output logic             reading
);

    csb_state_e       state_nx;
    logic [LAT_W-1:0] timer;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (arm) state_nx = ST_ACQ;
            ST_ACQ:   if (trig) state_nx = (latency == '0) ? ST_READ : ST_DELAY;
            ST_DELAY: if (timer == LAT_W'(1)) state_nx = ST_READ;
            ST_READ:  if (rd_done) state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // latency counter: loaded on the trigger edge, counts down in DELAY
    always_ff @(posedge clk) begin
        if (!rst_n)                      timer <= '0;
        else if (state == ST_ACQ && trig) timer <= latency;
        else if (state == ST_DELAY)      timer <= timer - 1'b1;
    end

    // outputs
    always_comb begin
        start_acq  = 1'b0;
        freeze     = 1'b0;
        we         = 1'b0;
        acq_active = 1'b0;
        reading    = 1'b0;
        unique case (state)
            ST_IDLE: start_acq = arm;
            ST_ACQ: begin
                we         = 1'b1;
                acq_active = 1'b1;
                freeze     = trig && (latency == '0);
            end
            ST_DELAY: begin
                we         = 1'b1;
                acq_active = 1'b1;
                freeze     = (timer == LAT_W'(1));
            end
            ST_READ: reading = 1'b1;
        endcase
    end

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !arm) |=> (state == ST_IDLE));

    // R13
    read_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |=> (state == ST_READ || state == ST_IDLE));

    // R5
    delay_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && timer > LAT_W'(1)) |=>
            (state == ST_DELAY && timer == $past(timer) - 1'b1));

endmodule

// File: rtl/csb_wr_ptr.sv
module csb_wr_ptr #(
    parameter int AW   = 9,
    parameter int RL_W = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            we,
    input  logic [RL_W-1:0] ring_len,
    output logic [AW-1:0]   wp,
    output logic [AW-1:0]   wp_nxt
);

    logic [RL_W-1:0] inc;

    always_comb begin
        inc    = {1'b0, wp} + 1'b1;
        wp_nxt = (inc == ring_len) ? '0 : inc[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   wp <= '0;
        else if (load) wp <= '0;
        else if (we)   wp <= wp_nxt;
    end

    // R2
    wp_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, wp} < ring_len));

    // R11
    wp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !load) |=> $stable(wp));

endmodule

// File: rtl/csb_cell_store.sv
module csb_cell_store #(
    parameter int DATA_W    = 12,
    parameter int SEG_CELLS = 64,
    parameter int NUM_SEG   = 8,
    parameter int AW        = $clog2(SEG_CELLS * NUM_SEG)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int SEG_AW = $clog2(SEG_CELLS);
    localparam int SEL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

    logic [SEL_W-1:0]  wseg;
    logic [SEL_W-1:0]  rseg;
    logic [DATA_W-1:0] seg_q [NUM_SEG];

    assign wseg = SEL_W'(waddr >> SEG_AW);
    assign rseg = SEL_W'(raddr >> SEG_AW);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        logic [DATA_W-1:0] cells [SEG_CELLS];

        always_ff @(posedge clk) begin
            if (we && wseg == SEL_W'(g))
                cells[waddr[SEG_AW-1:0]] <= wdata;
        end

        assign seg_q[g] = cells[raddr[SEG_AW-1:0]];
    end

    assign rdata = seg_q[rseg];

endmodule

// File: rtl/csb_rd_seq.sv
module csb_rd_seq #(
    parameter int DATA_W = 12,
    parameter int AW     = 9,
    parameter int RL_W   = AW + 1,
    parameter int RD_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic [AW-1:0]     start_ptr,
    input  logic              active,
    input  logic [RL_W-1:0]   ring_len,
    input  logic [RL_W-1:0]   rd_len,
    input  logic [DATA_W-1:0] rd_word,
    output logic [AW-1:0]     rd_addr,
    output logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [AW-1:0]     stop_cell
);

    localparam int DIV_W = (RD_DIV > 1) ? $clog2(RD_DIV) : 1;

    logic [AW-1:0]    ptr;
    logic [AW-1:0]    ptr_nxt;
    logic [RL_W-1:0]  inc;
    logic [RL_W-1:0]  cnt;
    logic [DIV_W-1:0] div;
    logic             emit;

    always_comb begin
        inc     = {1'b0, ptr} + 1'b1;
        ptr_nxt = (inc == ring_len) ? '0 : inc[AW-1:0];
        emit    = active && (div == DIV_W'(RD_DIV - 1));
        done    = emit && (cnt == rd_len - 1'b1);
    end

    assign rd_addr = ptr;

    // pointer, count and rate divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            cnt       <= '0;
            div       <= '0;
            stop_cell <= '0;
        end else if (freeze) begin
            ptr       <= start_ptr;
            cnt       <= '0;
            div       <= '0;
            stop_cell <= start_ptr;
        end else if (active) begin
            div <= emit ? '0 : div + 1'b1;
            if (emit) begin
                ptr <= ptr_nxt;
                cnt <= cnt + 1'b1;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= emit;
            rd_last  <= done;
            if (emit) rd_data <= rd_word;
        end
    end

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RD_DIV > 1 && rd_valid) |=> !rd_valid);

    // R10
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < rd_len));

endmodule

// File: rtl/csb_trig_ctrl.sv
module csb_trig_ctrl
    import csb_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int SEG_CELLS = 64,
    parameter int NUM_SEG   = 8,
    parameter int LAT_W     = 8,
    parameter int RD_DIV    = 4,
    parameter int AW        = $clog2(SEG_CELLS * NUM_SEG),
    parameter int MODE_W    = ($clog2(NUM_SEG) > 0) ? $clog2($clog2(NUM_SEG) + 1) : 1,
    parameter int RL_W      = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig,
    input  logic [MODE_W-1:0] cascade_sel,
    input  logic [LAT_W-1:0]  latency,
    input  logic [RL_W-1:0]   read_len,
    input  logic [DATA_W-1:0] samp_in,
    output logic              acq_active,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [AW-1:0]     stop_cell
);

    localparam int MAX_MODE = $clog2(NUM_SEG);

    csb_state_e        state;
    logic              start_acq;
    logic              freeze;
    logic              we;
    logic              reading;
    logic              rd_done;
    logic [MODE_W-1:0] mode_q;
    logic [MODE_W-1:0] mode_eff;
    logic [RL_W-1:0]   rlen_q;
    logic [RL_W-1:0]   ring_len;
    logic [RL_W-1:0]   rd_len_eff;
    logic [AW-1:0]     wp;
    logic [AW-1:0]     wp_nxt;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] rd_word;

    // configuration captured at the arm edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            rlen_q <= '0;
        end else if (start_acq) begin
            mode_q <= cascade_sel;
            rlen_q <= read_len;
        end
    end

    always_comb begin
        mode_eff   = (mode_q > MODE_W'(MAX_MODE)) ? MODE_W'(MAX_MODE) : mode_q;
        ring_len   = RL_W'(SEG_CELLS) << mode_eff;
        rd_len_eff = (rlen_q == '0 || rlen_q > ring_len) ? ring_len : rlen_q;
    end

    csb_ctrl_fsm #(.LAT_W(LAT_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .trig       (trig),
        .latency    (latency),
        .rd_done    (rd_done),
        .state      (state),
        .start_acq  (start_acq),
        .freeze     (freeze),
        .we         (we),
        .acq_active (acq_active),
        .reading    (reading)
    );

    csb_wr_ptr #(.AW(AW), .RL_W(RL_W)) wptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_acq),
        .we       (we),
        .ring_len (ring_len),
        .wp       (wp),
        .wp_nxt   (wp_nxt)
    );

    csb_cell_store #(
        .DATA_W    (DATA_W),
        .SEG_CELLS (SEG_CELLS),
        .NUM_SEG   (NUM_SEG),
        .AW        (AW)
    ) store_i (
        .clk   (clk),
        .we    (we),
        .waddr (wp),
        .wdata (samp_in),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    csb_rd_seq #(
        .DATA_W (DATA_W),
        .AW     (AW),
        .RL_W   (RL_W),
        .RD_DIV (RD_DIV)
    ) rdseq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (freeze),
        .start_ptr (wp_nxt),
        .active    (reading),
        .ring_len  (ring_len),
        .rd_len    (rd_len_eff),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .done      (rd_done),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_last   (rd_last),
        .stop_cell (stop_cell)
    );

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> $stable(stop_cell));

    // R13
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |=> !acq_active);

endmodule

// File: tb/csb_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module csb_trig_ctrl_tb_top;

    localparam int RD = 4;
    localparam int SEG = 64;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  lat;
        logic [9:0]  rlen;
        logic [11:0] pre;
        logic [2:0]  flags;   // 0: cfg change after arm, 1: retrigger in DELAY, 2: arm+trig in READ
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'd0,   10'd0,   12'd100, 3'b000},
        '{2'd1, 8'd5,   10'd10,  12'd200, 3'b001},
        '{2'd3, 8'd20,  10'd512, 12'd600, 3'b100},
        '{2'd2, 8'd255, 10'd1,   12'd300, 3'b000},
        '{2'd3, 8'd9,   10'd700, 12'd530, 3'b010},
        '{2'd0, 8'd0,   10'd64,  12'd63,  3'b000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  cascade_sel = '0;
    logic [7:0]  latency = '0;
    logic [9:0]  read_len = '0;
    logic [11:0] samp_in = '0;
    logic        acq_active;
    logic        rd_valid;
    logic [11:0] rd_data;
    logic        rd_last;
    logic [8:0]  stop_cell;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  tcyc = 0;
    logic [11:0] tval = '0;
    logic rec_en = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    always @(negedge clk) samp_in <= samp_in + 1'b1;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (rec_en) begin
        tval <= samp_in;
        tcyc <= cyc;
    end

    csb_trig_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .trig        (trig),
        .cascade_sel (cascade_sel),
        .latency     (latency),
        .read_len    (read_len),
        .samp_in     (samp_in),
        .acq_active  (acq_active),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rd_last     (rd_last),
        .stop_cell   (stop_cell)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int len, eff, stop, vlast, k, n;
        bit done;
        len = SEG << v.mode;
        eff = (v.rlen == 0 || int'(v.rlen) > len) ? len : int'(v.rlen);
        @(negedge clk);
        cascade_sel = v.mode;
        read_len    = v.rlen;
        latency     = v.lat;
        arm         = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        chk(acq_active == 1'b1, "R2 armed", acq_active, 1);
        if (v.flags[0]) begin
            cascade_sel = v.mode ^ 2'b01;   // R3 late change must not apply
            read_len    = v.rlen + 10'd7;
        end
        repeat (int'(v.pre)) @(negedge clk);
        trig = 1'b1; rec_en = 1'b1;
        @(negedge clk);
        trig = 1'b0; rec_en = 1'b0;
        if (v.lat == 0) chk(acq_active == 1'b0, "R4 frozen", acq_active, 0);
        else            chk(acq_active == 1'b1, "R5 delaying", acq_active, 1);
        if (v.flags[1]) begin
            trig = 1'b1;              // R12 retrigger in DELAY
            @(negedge clk);
            trig = 1'b0;
            @(negedge clk);
        end
        stop  = (int'(v.pre) + 1 + int'(v.lat)) % len;
        vlast = int'(tval) + int'(v.lat);
        k = 0; n = 0; done = 1'b0;
        while (!done && n < 6000) begin
            @(negedge clk);
            n++;
            if (v.flags[2] && n == int'(v.lat) + 6) begin arm = 1'b1; trig = 1'b1; end
            if (v.flags[2] && n == int'(v.lat) + 7) begin arm = 1'b0; trig = 1'b0; end
            if (rd_valid) begin
                logic [11:0] ev;
                ev = 12'(vlast - len + 1 + k);
                if (k == 0) chk(stop_cell == 9'(stop), "R6 stop_cell", stop_cell, stop);
                chk(rd_data == ev, "R7 R11 data", rd_data, ev);
                chk(cyc == tcyc + int'(v.lat) + RD * (k + 1) + 1, "R9 timing", cyc,
                    tcyc + int'(v.lat) + RD * (k + 1) + 1);
                chk(rd_last == (k == eff - 1), "R10 last", rd_last, (k == eff - 1));
                if (rd_last) done = 1'b1;
                k++;
            end
        end
        chk(k == eff, "R8 R3 count", k, eff);
        begin
            int hi;
            hi = 0;
            repeat (20) begin
                @(negedge clk);
                if (acq_active || rd_valid) hi++;
            end
            chk(hi == 0, "R13 R12 stays idle", hi, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(acq_active == 1'b0, "R1 acq_active", acq_active, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(rd_last == 1'b0, "R1 rd_last", rd_last, 0);
        chk(stop_cell == '0, "R1 stop_cell", stop_cell, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 trigger while idle
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        begin
            int hi;
            hi = 0;
            repeat (30) begin
                @(negedge clk);
                if (acq_active || rd_valid) hi++;
            end
            chk(hi == 0, "R12 idle trigger", hi, 0);
        end
        for (int i = 0; i < 6; i++) run_vec(VECS[i]);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule